// File: doc/BRIEF.md
# Instruction-fetch translation buffer

This block translates a 32-bit virtual instruction-fetch address into a 29-bit physical address through a small, fully associative set of translation entries. Each entry has its own page size of 1 KB, 4 KB, 64 KB or 1 MB. An entry compares only the virtual address bits above its own page boundary. Below that boundary, the untranslated virtual offset passes straight through into the physical address. Address-space matching applies to every entry unless the entry is marked shared. A single protection bit per entry limits access to privileged mode.

The fetch unit presents an address, the current address-space ID and the privilege mode. In the same cycle the block returns exactly one outcome: hit, miss, protection fault or multiple-hit error. With a hit it also returns the physical address and the cacheable attribute. A unified translation controller refills one entry per cycle. The refill goes to the lowest-numbered invalid entry, or to the least-recently-used entry when every entry is valid. A flush input invalidates the whole buffer in one cycle.

Top module: `ifetch_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: Size code 00 = 1 KB, 01 = 4 KB, 10 = 64 KB and 11 = 1 MB. An entry matches when the virtual address bits 31 down to the page boundary (bit 10, 12, 16 or 20) equal the entry's stored page number in those bits. Bits below the boundary are ignored.
- R3: On a hit, the physical address takes bits 28 down to the page boundary from the entry's physical page number. Its bits below the boundary are copied from the virtual address.
- R4: A matching entry counts only if its shared bit is 1 or its address-space ID equals the lookup's ID.
- R5: When two or more entries match, the lookup reports a multiple-hit error. Hit and protection fault stay low in that case.
- R6: Each entry stores the upper bit of the refill's 2-bit protection field (input fill_prot_hi). When that bit is 1 and the lookup is in user mode (lk_priv = 0), a single match reports a protection fault instead of a hit.
- R7: A refill writes the lowest-numbered invalid entry.
- R8: When all entries are valid, a refill replaces the least-recently-used entry. Hits and refills make their entry the most recent. Protection faults, misses and multiple hits change nothing. After reset the recency order from most to least recent is entry 0, 1, 2, 3.
- R9: Flush invalidates every entry at the next clock edge, and a refill in the same cycle is discarded. A lookup in the same cycle as a flush reports a miss.
- R10: While lk_req is 1, exactly one of hit, miss, protection fault and multiple hit is 1. While lk_req is 0, all four are 0. The physical address is 0 unless there is a hit.
- R11: lk_cacheable equals the hit entry's cacheable bit on a hit, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual fetch address |
| lk_asid | input | 8 | Current address-space ID |
| lk_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No entry matched |
| lk_prot_fault | output | 1 | User-mode access to a privileged-only page |
| lk_multi | output | 1 | More than one entry matched |
| lk_paddr | output | 29 | Translated physical address |
| lk_cacheable | output | 1 | Cacheable attribute of the hit page |
| fill_we | input | 1 | Refill strobe |
| fill_vpn | input | 22 | Virtual page number, address bits 31:10 |
| fill_asid | input | 8 | Address-space ID of the refilled entry |
| fill_ppn | input | 19 | Physical page number, address bits 28:10 |
| fill_size | input | 2 | Page size code |
| fill_shared | input | 1 | Shared page, bypasses the address-space match |
| fill_cacheable | input | 1 | Cacheable attribute |
| fill_prot_hi | input | 1 | Upper bit of the unified buffer's protection field |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench sweeps every page size with offsets across the whole page and with addresses one byte outside each end of the page. A design that masked the wrong number of bits would hit outside the page, or miss inside it, and would also corrupt the physical address bits passed through from the offset.

Lookups run with matching and mismatching address-space IDs, with shared pages, and in both privilege modes. These expose an override that was ignored, or a protection check that was inverted.

A long pseudo-random mix of refills and lookups over more pages than there are entries checks the replacement choice on every lookup. A design that evicted the wrong entry, updated recency on a fault, or ignored free slots would lose a page the reference model still holds.

Further cases cover:
- overlapping pages, which must raise a multiple-hit error;
- a flush together with a lookup or a refill;
- idle cycles, where no outcome flag may be raised.

// File: rtl/ifetch_tlb_pkg.sv
package ifetch_tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 29;
    localparam int PG_LSB = 10;
    localparam int ASID_W = 8;
    localparam int VPN_W  = VA_W - PG_LSB;
    localparam int PPN_W  = PA_W - PG_LSB;

    typedef enum logic [1:0] {
        PG_1K  = 2'b00,
        PG_4K  = 2'b01,
        PG_64K = 2'b10,
        PG_1M  = 2'b11
    } pg_size_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        pg_size_e          size;
        logic              shared;
        logic              cacheable;
        logic              priv_only;
    } tlb_ent_t;

    // One bit per page-number bit: 1 = part of the compared page number
    function automatic logic [VPN_W-1:0] page_mask(pg_size_e sz);
        logic [VPN_W-1:0] ones;
        ones = '1;
        case (sz)
            PG_1K:   page_mask = ones;
            PG_4K:   page_mask = ones << 2;
            PG_64K:  page_mask = ones << 6;
            default: page_mask = ones << 10;
        endcase
    endfunction
endpackage

// File: rtl/ifetch_tlb_cmp.sv
module ifetch_tlb_cmp
    import ifetch_tlb_pkg::*;
(
    input  tlb_ent_t          ent,
    input  logic [VPN_W-1:0]  va_vpn,
    input  logic [ASID_W-1:0] asid,
    output logic              match,
    output logic [PPN_W-1:0]  pa_page
);
    logic [VPN_W-1:0] mask;
    logic [PPN_W-1:0] pmask;
    logic             page_eq;
    logic             space_ok;

    always_comb begin
        mask     = page_mask(ent.size);
        pmask    = mask[PPN_W-1:0];
        page_eq  = ((ent.vpn ^ va_vpn) & mask) == '0;
        space_ok = ent.shared || (ent.asid == asid);
        match    = ent.valid && page_eq && space_ok;
        pa_page  = (ent.ppn & pmask) | (va_vpn[PPN_W-1:0] & ~pmask);
    end
endmodule

// File: rtl/ifetch_tlb_lru.sv
module ifetch_tlb_lru #(
    parameter int NUM = 4,
    localparam int IW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] lru_idx
);
    typedef struct packed {
        logic [NUM-1:0][IW-1:0] rank;
    } lru_st_t;

    lru_st_t        st_d, st_q;
    logic [NUM-1:0] oldest;

    always_comb begin
        st_d = st_q;
        if (touch_en) begin
            for (int i = 0; i < NUM; i++) begin
                if (st_q.rank[i] < st_q.rank[touch_idx]) begin
                    st_d.rank[i] = st_q.rank[i] + 1'b1;
                end
            end
            st_d.rank[touch_idx] = '0;
        end
        lru_idx = '0;
        oldest  = '0;
        for (int i = 0; i < NUM; i++) begin
            if (st_q.rank[i] == IW'(NUM - 1)) begin
                lru_idx   = IW'(i);
                oldest[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin
                st_q.rank[i] <= IW'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest)); // R8
    AST_LRU_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (st_q.rank[$past(touch_idx)] == '0)); // R8
endmodule

// File: rtl/ifetch_tlb.sv
module ifetch_tlb
    import ifetch_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_req,
    input  logic [VA_W-1:0]       lk_va,
    input  logic [ASID_W-1:0]     lk_asid,
    input  logic                  lk_priv,
    output logic                  lk_hit,
    output logic                  lk_miss,
    output logic                  lk_prot_fault,
    output logic                  lk_multi,
    output logic [PA_W-1:0]       lk_paddr,
    output logic                  lk_cacheable,
    input  logic                  fill_we,
    input  logic [VPN_W-1:0]      fill_vpn,
    input  logic [ASID_W-1:0]     fill_asid,
    input  logic [PPN_W-1:0]      fill_ppn,
    input  logic [1:0]            fill_size,
    input  logic                  fill_shared,
    input  logic                  fill_cacheable,
    input  logic                  fill_prot_hi,
    input  logic                  flush
);
    localparam int IW = $clog2(NUM_ENTRIES);
    localparam int CW = $clog2(NUM_ENTRIES + 1);

    typedef struct packed {
        tlb_ent_t [NUM_ENTRIES-1:0] ent;
    } tlb_st_t;

    tlb_st_t                         st_d, st_q;
    logic [NUM_ENTRIES-1:0]          match_vec;
    logic [NUM_ENTRIES-1:0][PPN_W-1:0] pa_page;
    logic [VPN_W-1:0]                va_vpn;
    logic [CW-1:0]                   n_match;
    logic [IW-1:0]                   hit_idx;
    logic [IW-1:0]                   victim;
    logic [IW-1:0]                   lru_idx;
    logic                            free_found;
    logic                            single;
    logic                            touch_en;
    logic [IW-1:0]                   touch_idx;

    assign va_vpn = lk_va[VA_W-1:PG_LSB];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        ifetch_tlb_cmp u_cmp (
            .ent     (st_q.ent[g]),
            .va_vpn  (va_vpn),
            .asid    (lk_asid),
            .match   (match_vec[g]),
            .pa_page (pa_page[g])
        );
    end

    ifetch_tlb_lru #(.NUM(NUM_ENTRIES)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    always_comb begin
        // lookup outcome
        n_match = '0;
        hit_idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match_vec[i]) begin
                n_match = n_match + 1'b1;
                hit_idx = IW'(i);
            end
        end
        single        = lk_req && !flush && (n_match == CW'(1));
        lk_multi      = lk_req && !flush && (n_match > CW'(1));
        lk_miss       = lk_req && (flush || (n_match == '0));
        lk_prot_fault = single && st_q.ent[hit_idx].priv_only && !lk_priv;
        lk_hit        = single && !lk_prot_fault;
        lk_paddr      = lk_hit ? {pa_page[hit_idx], lk_va[PG_LSB-1:0]} : '0;
        lk_cacheable  = lk_hit && st_q.ent[hit_idx].cacheable;

        // refill victim: lowest free slot, else least recent
        victim     = '0;
        free_found = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!st_q.ent[i].valid && !free_found) begin
                victim     = IW'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            victim = lru_idx;
        end

        // next state
        st_d      = st_q;
        touch_en  = 1'b0;
        touch_idx = hit_idx;
        if (flush) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                st_d.ent[i].valid = 1'b0;
            end
        end else if (fill_we) begin
            st_d.ent[victim].valid     = 1'b1;
            st_d.ent[victim].vpn       = fill_vpn;
            st_d.ent[victim].asid      = fill_asid;
            st_d.ent[victim].ppn       = fill_ppn;
            st_d.ent[victim].size      = pg_size_e'(fill_size);
            st_d.ent[victim].shared    = fill_shared;
            st_d.ent[victim].cacheable = fill_cacheable;
            st_d.ent[victim].priv_only = fill_prot_hi;
            touch_en  = 1'b1;
            touch_idx = victim;
        end else if (lk_hit) begin
            touch_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> $countones({lk_hit, lk_miss, lk_prot_fault, lk_multi}) == 1); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_miss || lk_prot_fault || lk_multi)); // R10
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[PG_LSB-1:0] == lk_va[PG_LSB-1:0]); // R3
    AST_FAULT_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_prot_fault |-> !lk_priv); // R6
    AST_NO_CACHE_OFF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> !lk_cacheable); // R11
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && lk_req) |-> lk_miss); // R9
    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && !flush) |=> (st_q.ent[$past(victim)].valid)); // R7
endmodule

// File: tb/ifetch_tlb_bench.sv
module ifetch_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_priv = 1'b0;
    logic        lk_hit, lk_miss, lk_prot_fault, lk_multi, lk_cacheable;
    logic [28:0] lk_paddr;
    logic        fill_we = 1'b0;
    logic [21:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [18:0] fill_ppn = '0;
    logic [1:0]  fill_size = '0;
    logic        fill_shared = 1'b0, fill_cacheable = 1'b0, fill_prot_hi = 1'b0;
    logic        flush = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model
    bit          m_valid [4];
    logic [21:0] m_vpn   [4];
    logic [7:0]  m_asid  [4];
    logic [18:0] m_ppn   [4];
    logic [1:0]  m_size  [4];
    bit          m_sh [4], m_c [4], m_p [4];
    int          m_rank  [4];

    always #4 clk = ~clk;

    ifetch_tlb u_ifetch_tlb (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid),
        .lk_priv(lk_priv), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_prot_fault(lk_prot_fault),
        .lk_multi(lk_multi), .lk_paddr(lk_paddr), .lk_cacheable(lk_cacheable),
        .fill_we(fill_we), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_ppn(fill_ppn),
        .fill_size(fill_size), .fill_shared(fill_shared), .fill_cacheable(fill_cacheable),
        .fill_prot_hi(fill_prot_hi), .flush(flush)
    );

    function automatic int shift_of(input logic [1:0] s);
        case (s)
            2'b00: return 10;
            2'b01: return 12;
            2'b10: return 16;
            default: return 20;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic touch(input int k);
        for (int j = 0; j < 4; j++) if (m_rank[j] < m_rank[k]) m_rank[j]++;
        m_rank[k] = 0;
    endtask

    task automatic model_reset();
        for (int j = 0; j < 4; j++) begin
            m_valid[j] = 0;
            m_rank[j] = j;
        end
    endtask

    task automatic quiet();
        lk_req = 0; fill_we = 0; flush = 0;
    endtask

    // drives one lookup and compares all outputs with the model
    task automatic look(input logic [31:0] va, input logic [7:0] asid, input bit pr,
                        input bit with_flush, input string tag);
        int n; int idx; int sh;
        logic [3:0] ef; logic [28:0] epa; bit ec;
        @(negedge clk);
        quiet();
        lk_req = 1; lk_va = va; lk_asid = asid; lk_priv = pr; flush = with_flush;
        n = 0; idx = 0;
        for (int j = 0; j < 4; j++) begin
            sh = shift_of(m_size[j]);
            if (m_valid[j] && ((va >> sh) == ({m_vpn[j], 10'b0} >> sh)) &&
                (m_sh[j] || m_asid[j] == asid)) begin
                n++; idx = j;
            end
        end
        epa = '0; ec = 0;
        if (with_flush || n == 0) ef = 4'b0100;
        else if (n > 1)           ef = 4'b0001;
        else if (m_p[idx] && !pr) ef = 4'b0010;
        else begin
            ef = 4'b1000;
            sh = shift_of(m_size[idx]);
            epa = 29'((({m_ppn[idx], 10'b0} >> sh) << sh) | (va & ((32'd1 << sh) - 1)));
            ec = m_c[idx];
        end
        #2;
        check({lk_hit, lk_miss, lk_prot_fault, lk_multi} == ef, {tag, " outcome"},
              64'({lk_hit, lk_miss, lk_prot_fault, lk_multi}), 64'(ef));
        check(lk_paddr == epa, {tag, " paddr R3"}, 64'(lk_paddr), 64'(epa));
        check(lk_cacheable == ec, {tag, " cacheable R11"}, 64'(lk_cacheable), 64'(ec));
        if (with_flush) for (int j = 0; j < 4; j++) m_valid[j] = 0;
        else if (ef == 4'b1000) touch(idx);
        @(posedge clk);
    endtask

    task automatic fill(input logic [31:0] va, input logic [7:0] asid, input logic [18:0] ppn,
                        input logic [1:0] sz, input bit sh, input bit c, input logic [1:0] prot,
                        input bit with_flush);
        int v;
        @(negedge clk);
        quiet();
        fill_we = 1; fill_vpn = va[31:10]; fill_asid = asid; fill_ppn = ppn; fill_size = sz;
        fill_shared = sh; fill_cacheable = c; fill_prot_hi = prot[1]; flush = with_flush;
        if (with_flush) begin
            for (int j = 0; j < 4; j++) m_valid[j] = 0;
        end else begin
            v = -1;
            for (int j = 0; j < 4; j++) if (!m_valid[j] && v < 0) v = j;
            if (v < 0) for (int j = 0; j < 4; j++) if (m_rank[j] == 3) v = j;
            m_valid[v] = 1; m_vpn[v] = va[31:10]; m_asid[v] = asid; m_ppn[v] = ppn;
            m_size[v] = sz; m_sh[v] = sh; m_c[v] = c; m_p[v] = prot[1];
            touch(v);
        end
        @(posedge clk);
    endtask

    logic [31:0] base [4];
    logic [7:0]  own  [4];

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: empty after reset
        look(32'h0000_0400, 8'd1, 1, 0, "R1");
        look(32'h8A10_0000, 8'd0, 0, 0, "R1");

        // R10: idle cycle raises nothing
        @(negedge clk); quiet(); #2;
        check({lk_hit, lk_miss, lk_prot_fault, lk_multi} == 4'b0, "R10 idle",
              64'({lk_hit, lk_miss, lk_prot_fault, lk_multi}), 64'(0));

        // R7: four fills land in free slots
        base[0] = 32'h0000_0400; own[0] = 8'd1;
        base[1] = 32'h1234_5000; own[1] = 8'd2;
        base[2] = 32'h4567_0000; own[2] = 8'd3;
        base[3] = 32'h8A10_0000; own[3] = 8'd4;
        fill(base[0], own[0], 19'h1_2345, 2'b00, 0, 1, 2'b00, 0);
        fill(base[1], own[1], 19'h0_0ABC, 2'b01, 1, 0, 2'b11, 0);
        fill(base[2], own[2], 19'h5_5555, 2'b10, 0, 1, 2'b10, 0);
        fill(base[3], own[3], 19'h7_FFFF, 2'b11, 0, 1, 2'b01, 0);

        // R2 R3 R4 R6 R11: sweep each page size
        for (int k = 0; k < 4; k++) begin
            int sh;
            sh = shift_of(2'(k));
            for (int t = 0; t < 8; t++) begin
                logic [31:0] va;
                va = base[k] + 32'(t) * ((32'd1 << sh) >> 3) + 32'(t * 5);
                look(va, own[k], 1, 0, "R2 R3");
                look(va, own[k] + 8'd9, 1, 0, "R4");
                look(va, own[k], 0, 0, "R6");
            end
            look(base[k] - 32'd1, own[k], 1, 0, "R2 below");
            look(base[k] + (32'd1 << sh), own[k], 1, 0, "R2 above");
            look(base[k] + (32'd1 << sh) - 32'd1, own[k], 1, 0, "R2 last");
        end

        // R5: overlapping pages
        fill(32'h0, 8'd0, 19'h0, 2'b00, 0, 0, 2'b00, 1);
        fill(32'h3000_0000, 8'd6, 19'h1_0000, 2'b11, 0, 1, 2'b10, 0);
        fill(32'h3004_5000, 8'd6, 19'h0_2222, 2'b01, 1, 0, 2'b00, 0);
        look(32'h3004_5123, 8'd6, 1, 0, "R5 multi");
        look(32'h3004_5123, 8'd6, 0, 0, "R5 multi user");
        look(32'h3004_5123, 8'd7, 0, 0, "R4 shared only");
        look(32'h3001_0000, 8'd6, 1, 0, "R5 single");

        // R9: flush with lookup, then empty; flush beats refill
        look(32'h3001_0000, 8'd6, 1, 1, "R9 same cycle");
        look(32'h3001_0000, 8'd6, 1, 0, "R9 after");
        fill(32'h3001_0000, 8'd6, 19'h3, 2'b00, 0, 0, 2'b00, 1);
        look(32'h3001_0000, 8'd6, 1, 0, "R9 fill dropped");

        // R7 R8: random refills and lookups over eight 1K pages
        lfsr = 16'hACE1;
        for (int it = 0; it < 300; it++) begin
            int c;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = int'(lfsr[2:0]);
            if (lfsr[7:5] == 3'b000)
                fill(32'h2000_0000 + 32'(c) * 32'h1_0000, 8'd5, 19'(c * 19'h111), 2'b00,
                     0, lfsr[8], {lfsr[9], 1'b0}, 0);
            else if (lfsr[7:4] == 4'b1111)
                look(32'h2000_0000, 8'd5, 1, 1, "R9 flush");
            else
                look(32'h2000_0000 + 32'(c) * 32'h1_0000 + 32'(lfsr[15:10]), 8'd5,
                     lfsr[11], 0, "R7 R8");
        end

        @(negedge clk); quiet();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule